// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the control side of a block-erase flash memory as it appears on its asynchronous bus pins. The pins are active-low chip select (`ce_n`), read strobe (`oe_n`), write strobe (`we_n`) and reset/power-down (`rp_n`), all sampled on a fast system clock. Bus writes are decoded as commands, and those commands choose what a bus read returns: array contents, a two-word identifier, or an 8-bit status byte. Two of the commands start a timed operation on the array: a word program, or an erase of a whole block. While an operation runs, `rdy_busy` is low.

The bus behaves as a tri-state port through `dout` and `dout_en`. When `dout_en` is low the bus is released and `dout` is held at zero. Pulling `rp_n` low puts the block into deep power-down. This releases the bus, forgets any half-entered command sequence and aborts a running operation. The aborted block is then flagged on `blk_invalid` until it is erased successfully. The array is a small behavioural stub: programming can only clear bits, and erasing sets every word of a block to all ones. The durations of both operations are parameter cycle counts.

Top module: `flash_cui_ctrl`

## Requirements
- R1: A bus write is seen only while `we_n`=0, `ce_n`=0, `oe_n`=1 and `rp_n`=1. It takes effect in the cycle where `we_n` or `ce_n` first returns high, and it uses the address and data that were present in the last cycle with both low.
- R2: Command codes are taken from data bits 7:0. 0xFF selects array read and 0x90 selects identifier read. In identifier read, address bit 0 = 0 returns 0x00A5 and bit 0 = 1 returns 0x5A3C. 0x70 selects status read. Any unlisted code is ignored.
- R3: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `rp_n`=1. Otherwise `dout_en`=0 and `dout`=0.
- R4: The status byte sits in `dout[7:0]` with the upper bits zero. Bit 7 is ready (1 when idle), bit 5 is the erase error and bit 4 is the program error; all other bits are 0. Code 0x50 clears bits 5 and 4 and leaves the read source unchanged.
- R5: Code 0x40 followed by a second write starts a program. The data of the second write is ANDed into the addressed word, and the read source becomes status.
- R6: Code 0x20 followed by 0xD0 erases the block selected by the top two address bits of the confirm write, which sets every word in it to 0xFFFF. `rdy_busy` is low for ERASE_CYC cycles, and the erase clears that block's `blk_invalid` bit.
- R7: After 0x20, a second write with any code other than 0xD0 sets status bit 5, starts nothing, and selects array read.
- R8: `rdy_busy` is 0 for exactly PROG_CYC cycles after a program starts. Bus writes made while it is 0 are ignored.
- R9: Taking `ce_n` high during an operation does not stop it.
- R10: `rp_n`=0 during an operation aborts it. `rdy_busy` returns to 1 in the next cycle, and the `blk_invalid` bit of the target block is set.
- R11: After `rp_n` has been 0, the read source is array and the status byte reads 0x80. A half-entered program or erase sequence is forgotten.
- R12: A program whose target block has its `blk_invalid` bit set is refused. The refusal sets status bit 4, leaves `rdy_busy` at 1 and leaves the word unchanged.
- R13: After synchronous reset, every array word is 0xFFFF, `blk_invalid` is all zeros, the read source is array and the status byte is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Reset / deep power-down, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Bus write data |
| dout | output | DATA_W | Bus read data, zero when released |
| dout_en | output | 1 | Bus drive enable |
| rdy_busy | output | 1 | 1 when idle, 0 while an operation runs |
| blk_invalid | output | 2**BLK_W | One flag per block, set by an aborted operation |

## Verification
The hardest case to reach is power-down arriving while an operation is mid-flight. Reaching it needs a complete two-write sequence, a countdown left partly done, and then an `rp_n` pulse placed a few cycles into the busy window. The bench drives exactly that sequence during a program into block 2. After `rp_n` returns, it checks that the target word is unchanged, that the invalid flag is set, and that a later program into that block is refused until an erase clears the flag. A second `rp_n` pulse is placed between an erase setup and its confirm, to show that the half-entered sequence is forgotten.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_PROG  = 2'd1,
        PH_ERASE = 2'd2
    } cui_phase_e;

    typedef enum logic [1:0] {
        WSM_IDLE  = 2'd0,
        WSM_PROG  = 2'd1,
        WSM_ERASE = 2'd2
    } wsm_state_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
    } err_flags_t;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_IDENT   = 8'h90;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;

    localparam int ST_READY_BIT = 7;
    localparam int ST_ERASE_BIT = 5;
    localparam int ST_PROG_BIT  = 4;

    function automatic logic [7:0] pack_status(input logic ready, input err_flags_t e);
        logic [7:0] s;
        s = '0;
        s[ST_READY_BIT] = ready;
        s[ST_ERASE_BIT] = e.erase_err;
        s[ST_PROG_BIT]  = e.prog_err;
        return s;
    endfunction

endpackage

// File: rtl/fcc_bus_capture.sv
module fcc_bus_capture #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    logic              wr_now;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // A write cycle is open only with both strobes low and the read strobe high.
    assign wr_now = rp_n & ~we_n & ~ce_n & oe_n;

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now) begin
                addr_q <= addr;
                data_q <= wdata;
            end
        end
    end

    // Whichever strobe rises first closes the cycle.
    assign cmd_valid = wr_q & ~wr_now & rp_n;
    assign cmd_addr  = addr_q;
    assign cmd_data  = data_q;

endmodule

// File: rtl/fcc_cui.sv
module fcc_cui
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 2,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              busy,
    input  logic [NBLK-1:0]   blk_invalid,
    output rd_src_e           rd_src,
    output err_flags_t        errs,
    output logic              start_prog,
    output logic              start_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    cui_phase_e       phase;
    logic             accept;
    logic [7:0]       code;
    logic [BLK_W-1:0] blk;
    logic             blk_bad;

    assign accept  = cmd_valid & ~busy;
    assign code    = cmd_data[7:0];
    assign blk     = cmd_addr[ADDR_W-1 -: BLK_W];
    assign blk_bad = blk_invalid[blk];
    assign op_addr = cmd_addr;
    assign op_data = cmd_data;

    always_comb begin
        start_prog  = 1'b0;
        start_erase = 1'b0;
        if (accept) begin
            if (phase == PH_PROG && !blk_bad) begin
                start_prog = 1'b1;
            end
            if (phase == PH_ERASE && code == CMD_CONFIRM) begin
                start_erase = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            rd_src <= SRC_ARRAY;
            phase  <= PH_CMD;
            errs   <= '0;
        end else if (accept) begin
            unique case (phase)
                PH_PROG: begin
                    if (blk_bad) begin
                        errs.prog_err <= 1'b1;
                    end
                    phase <= PH_CMD;
                end
                PH_ERASE: begin
                    if (code != CMD_CONFIRM) begin
                        errs.erase_err <= 1'b1;
                        rd_src         <= SRC_ARRAY;
                    end
                    phase <= PH_CMD;
                end
                default: begin
                    case (code)
                        CMD_READ_ARRAY:   rd_src <= SRC_ARRAY;
                        CMD_READ_IDENT:   rd_src <= SRC_IDENT;
                        CMD_READ_STATUS:  rd_src <= SRC_STATUS;
                        CMD_CLEAR_STATUS: errs   <= '0;
                        CMD_PROG_SETUP: begin
                            phase  <= PH_PROG;
                            rd_src <= SRC_STATUS;
                        end
                        CMD_ERASE_SETUP: begin
                            phase  <= PH_ERASE;
                            rd_src <= SRC_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
    import fcc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20,
    localparam int NBLK     = 1 << BLK_W,
    localparam int CNT_MAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
    localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    output logic              busy,
    output logic              op_done,
    output logic [NBLK-1:0]   blk_invalid,
    output logic              prog_we,
    output logic              erase_we,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic [BLK_W-1:0]  tgt_blk
);

    wsm_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign busy     = (state != WSM_IDLE);
    assign op_done  = busy && (cnt == '0);
    assign tgt_blk  = tgt_addr[ADDR_W-1 -: BLK_W];
    assign prog_we  = rp_n && (state == WSM_PROG)  && (cnt == '0);
    assign erase_we = rp_n && (state == WSM_ERASE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= WSM_IDLE;
            cnt         <= '0;
            blk_invalid <= '0;
            tgt_addr    <= '0;
            tgt_data    <= '0;
        end else if (!rp_n) begin
            // Power-down aborts the operation; the half-altered block is untrusted.
            if (state != WSM_IDLE) begin
                blk_invalid[tgt_blk] <= 1'b1;
            end
            state <= WSM_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                WSM_IDLE: begin
                    if (start_prog) begin
                        state    <= WSM_PROG;
                        cnt      <= CNT_W'(PROG_CYC - 1);
                        tgt_addr <= op_addr;
                        tgt_data <= op_data;
                    end else if (start_erase) begin
                        state    <= WSM_ERASE;
                        cnt      <= CNT_W'(ERASE_CYC - 1);
                        tgt_addr <= op_addr;
                        tgt_data <= op_data;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        if (state == WSM_ERASE) begin
                            blk_invalid[tgt_blk] <= 1'b0;
                        end
                        state <= WSM_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int BLK_W   = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int WORD_W = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_we,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [BLK_W-1:0]  MY_BLK  = BLK_W'(w >> WORD_W);
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(w);
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '1;
            end else if (erase_we && erase_blk == MY_BLK) begin
                mem[w] <= '1;
            end else if (prog_we && prog_addr == MY_ADDR) begin
                // Programming can only pull bits to zero.
                mem[w] <= mem[w] & prog_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_cui_ctrl.sv
module flash_cui_ctrl
    import fcc_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter int              DATA_W    = 16,
    parameter int              BLK_W     = 2,
    parameter int              PROG_CYC  = 8,
    parameter int              ERASE_CYC = 20,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00A5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h5A3C,
    localparam int             NBLK      = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rdy_busy,
    output logic [NBLK-1:0]   blk_invalid
);

    logic              cmd_valid;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    rd_src_e           rd_src;
    err_flags_t        errs;
    logic              start_prog;
    logic              start_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic              wsm_busy;
    logic              op_done;
    logic              prog_we;
    logic              erase_we;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;
    logic [BLK_W-1:0]  tgt_blk;
    logic [DATA_W-1:0] arr_data;
    logic [7:0]        status_q;
    logic [DATA_W-1:0] sel_data;

    fcc_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .addr(addr), .wdata(wdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    fcc_cui #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_cui (
        .clk(clk), .rst(rst), .rp_n(rp_n),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(wsm_busy), .blk_invalid(blk_invalid),
        .rd_src(rd_src), .errs(errs),
        .start_prog(start_prog), .start_erase(start_erase),
        .op_addr(op_addr), .op_data(op_data)
    );

    fcc_wsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_wsm (
        .clk(clk), .rst(rst), .rp_n(rp_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .op_addr(op_addr), .op_data(op_data),
        .busy(wsm_busy), .op_done(op_done), .blk_invalid(blk_invalid),
        .prog_we(prog_we), .erase_we(erase_we),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_blk(tgt_blk)
    );

    fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst(rst),
        .prog_we(prog_we), .prog_addr(tgt_addr), .prog_data(tgt_data),
        .erase_we(erase_we), .erase_blk(tgt_blk),
        .rd_addr(addr), .rd_data(arr_data)
    );

    assign status_q = pack_status(~wsm_busy, errs);
    assign rdy_busy = ~wsm_busy;
    assign dout_en  = rp_n & ~ce_n & ~oe_n;

    always_comb begin
        unique case (rd_src)
            SRC_IDENT:  sel_data = addr[0] ? DEV_CODE : MFR_CODE;
            SRC_STATUS: sel_data = DATA_W'(status_q);
            default:    sel_data = arr_data;
        endcase
    end

    assign dout = dout_en ? sel_data : '0;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
    import fcc_pkg::*;
#(
    parameter int BLK_W = 2,
    localparam int NBLK = 1 << BLK_W
) (
    input logic            clk,
    input logic            rst,
    input logic            rp_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            dout_en,
    input logic            rdy_busy,
    input logic            busy,
    input logic            op_done,
    input logic            cmd_valid,
    input rd_src_e         rd_src,
    input logic [7:0]      status_q,
    input logic [NBLK-1:0] blk_invalid
);

    p_bus_release_r3: assert property (@(posedge clk) disable iff (rst)
        (oe_n || ce_n || !rp_n) |-> !dout_en);

    p_busy_ignores_writes_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> $stable(rd_src));

    p_keeps_running_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && rp_n && !op_done) |=> !rdy_busy);

    p_abort_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !rp_n) |=> rdy_busy);

    p_abort_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !rp_n) |=> (blk_invalid != '0));

    p_powerdown_state_r11: assert property (@(posedge clk) disable iff (rst)
        !rp_n |=> (status_q == 8'h80 && rd_src == SRC_ARRAY));

endmodule

bind flash_cui_ctrl fcc_checker #(.BLK_W(BLK_W)) i_fcc_checker (
    .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n),
    .dout_en(dout_en), .rdy_busy(rdy_busy), .busy(wsm_busy), .op_done(op_done),
    .cmd_valid(cmd_valid), .rd_src(rd_src), .status_q(status_q),
    .blk_invalid(blk_invalid)
);

// File: tb/test_flash_cui_ctrl.sv
`timescale 1ns/1ps
module test_flash_cui_ctrl;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int BLK_W     = 2;
    localparam int NBLK      = 1 << BLK_W;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 20;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BSHIFT    = ADDR_W - BLK_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;
    logic              rdy_busy;
    logic [NBLK-1:0]   blk_invalid;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_cui_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) i_flash_cui_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .addr(addr), .wdata(wdata), .dout(dout), .dout_en(dout_en),
        .rdy_busy(rdy_busy), .blk_invalid(blk_invalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_mem [DEPTH];
    bit  m_act;
    int  m_aq, m_dq;
    int  m_src;      // 0 array, 1 ident, 2 status
    int  m_phase;    // 0 command, 1 program data, 2 erase confirm
    bit  m_errp, m_erre, m_busy;
    int  m_left, m_op, m_oa, m_od;
    bit [NBLK-1:0] m_inv;
    bit  m_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
            m_act = 0; m_aq = 0; m_dq = 0; m_src = 0; m_phase = 0;
            m_errp = 0; m_erre = 0; m_busy = 0; m_left = 0; m_op = 0; m_inv = '0;
            m_live = 1;
        end else if (!rp_n) begin
            if (m_busy) m_inv[m_oa >> BSHIFT] = 1'b1;
            m_busy = 0; m_src = 0; m_phase = 0; m_errp = 0; m_erre = 0; m_act = 0;
            m_aq = 0; m_dq = 0;
        end else begin
            bit act_now, commit, b_old;
            bit [NBLK-1:0] inv_old;
            act_now = !we_n && !ce_n && oe_n;
            commit  = m_act && !act_now;
            b_old   = m_busy;
            inv_old = m_inv;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_op == 1) m_mem[m_oa] = m_mem[m_oa] & m_od;
                    else begin
                        for (int i = 0; i < DEPTH; i++)
                            if ((i >> BSHIFT) == (m_oa >> BSHIFT)) m_mem[i] = 16'hFFFF;
                        m_inv[m_oa >> BSHIFT] = 1'b0;
                    end
                    m_busy = 0;
                end
            end
            if (commit && !b_old) begin
                int code;
                code = m_dq & 255;
                if (m_phase == 1) begin
                    if (inv_old[m_aq >> BSHIFT]) m_errp = 1;
                    else begin m_busy = 1; m_left = PROG_CYC; m_op = 1; m_oa = m_aq; m_od = m_dq; end
                    m_phase = 0;
                end else if (m_phase == 2) begin
                    if (code == 'hD0) begin m_busy = 1; m_left = ERASE_CYC; m_op = 2; m_oa = m_aq; end
                    else begin m_erre = 1; m_src = 0; end
                    m_phase = 0;
                end else begin
                    case (code)
                        'hFF: m_src = 0;
                        'h90: m_src = 1;
                        'h70: m_src = 2;
                        'h50: begin m_errp = 0; m_erre = 0; end
                        'h40: begin m_phase = 1; m_src = 2; end
                        'h20: begin m_phase = 2; m_src = 2; end
                        default: ;
                    endcase
                end
            end
            m_act = act_now;
            if (act_now) begin m_aq = int'(addr); m_dq = int'(wdata); end
        end
    end

    // Compare all outputs against the model once per cycle, away from the edge.
    always @(negedge clk) begin
        #1;
        if (m_live && !rst) begin
            bit en;
            int val;
            en = rp_n && !ce_n && !oe_n;
            if (!en) val = 0;
            else if (m_src == 0) val = m_mem[addr];
            else if (m_src == 1) val = addr[0] ? 'h5A3C : 'h00A5;
            else val = ((m_busy ? 0 : 1) << 7) | (int'(m_erre) << 5) | (int'(m_errp) << 4);
            chk("R3 model dout_en", 32'(dout_en), 32'(en));
            chk("R2 model dout", 32'(dout), 32'(val));
            chk("R8 model rdy_busy", 32'(rdy_busy), 32'(!m_busy));
            chk("R10 model blk_invalid", 32'(blk_invalid), 32'(m_inv));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input int a, input int d, input bit ce_first = 0);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = DATA_W'(d); oe_n = 1; ce_n = 0; we_n = 0;
        @(negedge clk);
        if (ce_first) ce_n = 1; else we_n = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic bus_read(input int a, output logic [DATA_W-1:0] d, output logic e);
        @(negedge clk);
        addr = ADDR_W'(a); we_n = 1; ce_n = 0; oe_n = 0;
        #1;
        d = dout; e = dout_en;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        forever begin
            #1;
            if (rdy_busy) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic e;
        int n;

        repeat (3) @(negedge clk);
        rst = 0;

        // R13: reset state
        bus_read(0, d, e);
        chk("R13 array erased after reset", 32'(d), 32'hFFFF);
        chk("R13 blk_invalid clear", 32'(blk_invalid), 32'h0);
        bus_write(0, 'h70);
        bus_read(0, d, e);
        chk("R13 status after reset", 32'(d), 32'h0080);

        // R2: identifier reads and unknown code
        bus_write(0, 'h90);
        bus_read(0, d, e);
        chk("R2 maker code", 32'(d), 32'h00A5);
        bus_read(1, d, e);
        chk("R2 device code", 32'(d), 32'h5A3C);
        bus_write(0, 'h33);
        bus_read(0, d, e);
        chk("R2 unknown code ignored", 32'(d), 32'h00A5);

        // R3: output disable and standby
        @(negedge clk); ce_n = 0; oe_n = 1; #1;
        chk("R3 oe_n high releases bus", 32'(dout_en), 32'h0);
        chk("R3 released bus reads zero", 32'(dout), 32'h0);
        @(negedge clk); ce_n = 1; oe_n = 0; #1;
        chk("R3 ce_n high releases bus", 32'(dout_en), 32'h0);
        @(negedge clk); oe_n = 1;

        // R5, R8, R9: program with ce_n held high through the busy window
        bus_write(0, 'hFF);
        bus_write(5, 'h40);
        bus_write(5, 'h1234);
        wait_ready(n);
        chk("R8 program busy length", 32'(n), 32'(PROG_CYC));
        chk("R9 ce_n high did not stop program", 32'(n), 32'(PROG_CYC));
        bus_read(0, d, e);
        chk("R5 read source is status after program", 32'(d), 32'h0080);
        bus_write(0, 'hFF);
        bus_read(5, d, e);
        chk("R5 programmed word", 32'(d), 32'h1234);

        // R8: writes during busy are ignored; status shows busy
        bus_write(5, 'h40);
        bus_write(5, 'hFF00);
        bus_read(0, d, e);
        chk("R8 status busy during program", 32'(d), 32'h0000);
        bus_write(0, 'hFF);
        wait_ready(n);
        bus_read(0, d, e);
        chk("R8 write during busy ignored", 32'(d), 32'h0080);
        bus_write(0, 'hFF);
        bus_read(5, d, e);
        chk("R5 program only clears bits", 32'(d), 32'h1200);

        // R6: erase block 0
        bus_write(3, 'h20);
        bus_write(3, 'hD0);
        wait_ready(n);
        chk("R6 erase busy length", 32'(n), 32'(ERASE_CYC));
        bus_write(0, 'hFF);
        bus_read(5, d, e);
        chk("R6 erased word", 32'(d), 32'hFFFF);

        // R7, R4: bad erase confirm, status format, clear
        bus_write(0, 'h20);
        bus_write(0, 'h33);
        chk("R7 no erase started", 32'(rdy_busy), 32'h1);
        bus_read(0, d, e);
        chk("R7 read source back to array", 32'(d), 32'hFFFF);
        bus_write(0, 'h70);
        bus_read(0, d, e);
        chk("R7 erase error bit", 32'(d), 32'h00A0);
        bus_write(0, 'h50);
        bus_read(0, d, e);
        chk("R4 clear status", 32'(d), 32'h0080);

        // R1: write with oe_n low is not a write; ce_n-first close is
        bus_write(0, 'hFF);
        @(negedge clk); addr = 1; wdata = 'h90; oe_n = 0; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; oe_n = 1;
        bus_read(1, d, e);
        chk("R1 write with oe_n low ignored", 32'(d), 32'hFFFF);
        bus_write(1, 'h90, 1);
        bus_read(1, d, e);
        chk("R1 ce_n-first write accepted", 32'(d), 32'h5A3C);
        bus_write(0, 'hFF);

        // R10, R11: abort a program into block 2
        bus_write(40, 'h40);
        bus_write(40, 'h0F0F);
        repeat (3) @(negedge clk);
        rp_n = 0; ce_n = 0; oe_n = 0;
        @(negedge clk); #1;
        chk("R10 ready right after abort", 32'(rdy_busy), 32'h1);
        chk("R3 bus released in power-down", 32'(dout_en), 32'h0);
        @(negedge clk);
        rp_n = 1; ce_n = 1; oe_n = 1;
        #1;
        chk("R10 target block flagged", 32'(blk_invalid), 32'h4);
        bus_read(40, d, e);
        chk("R11 array source after power-down", 32'(d), 32'hFFFF);
        bus_write(0, 'h70);
        bus_read(0, d, e);
        chk("R11 status 0x80 after power-down", 32'(d), 32'h0080);

        // R11: pending erase setup forgotten
        bus_write(0, 'hFF);
        bus_write(0, 'h20);
        @(negedge clk); rp_n = 0;
        @(negedge clk); rp_n = 1;
        bus_write(0, 'hD0);
        #1;
        chk("R11 confirm after power-down starts nothing", 32'(rdy_busy), 32'h1);
        bus_read(0, d, e);
        chk("R11 pending sequence dropped", 32'(d), 32'hFFFF);

        // R12: program into flagged block refused
        bus_write(40, 'h40);
        bus_write(40, 'h0000);
        #1;
        chk("R12 no busy on refused program", 32'(rdy_busy), 32'h1);
        bus_read(0, d, e);
        chk("R12 program error bit", 32'(d), 32'h0090);
        bus_write(0, 'h50);
        bus_write(0, 'hFF);
        bus_read(40, d, e);
        chk("R12 word unchanged", 32'(d), 32'hFFFF);

        // R6: erase clears the invalid flag
        bus_write(40, 'h20);
        bus_write(40, 'hD0);
        wait_ready(n);
        chk("R6 erase busy length block 2", 32'(n), 32'(ERASE_CYC));
        chk("R6 erase clears invalid flag", 32'(blk_invalid), 32'h0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule